// File: doc/BRIEF.md
# Data-Set-Ready Change Detector

This block is the modem-status part of a serial port, cut down to one handshake line: the active-low data-set-ready pin. The pin comes in asynchronous to the core clock. It is brought into the clock domain through a short flop chain. Software reads a status word that shows the asserted level of the line and a sticky change flag.

The change flag records every transition of the synchronized line, whichever way it goes. It stays set until software reads the status word. While the flag is set and the modem-status interrupt enable is on, a registered interrupt request is raised.

The read returns the flag as it was before the clear. A transition that lands in the same cycle as the clearing read is kept, so no edge is lost. Writes to the status word are ignored. When a read and a write hit together, the access counts as a write and does nothing.

Top module: `mdm_status_unit`

## Requirements
- R1: After synchronous reset, `rd_data` and `irq_modem` are 0. The synchronizer holds the inactive (high) pin level, so a first read with the pin high returns 0.
- R2: Bit 5 of the status word is the inverse of the synchronized pin. A read sees a pin change when the read strobe is sampled at the third rising edge after the change or later. The first of those edges is the one that captures the new pin value.
- R3: Bit 1 of the status word is the change flag. It is set at the third rising edge after the pin toggles, for falling and rising transitions alike.
- R4: A read (`reg_sel`=1, `reg_rd`=1, `reg_wr`=0) clears the change flag at that edge. The value returned carries the flag from before the clear.
- R5: If a transition is being detected in the same cycle as a clearing read, the flag stays set. That read returns the old flag value.
- R6: `irq_modem` is registered. After each edge it equals the change flag ANDed with `ie_modem` as sampled at that edge.
- R7: A write strobe (`reg_sel`=1, `reg_wr`=1) changes neither the flag nor `rd_data`. This includes the case where `reg_rd` is also 1.
- R8: All bits of `rd_data` other than 5 and 1 read as 0.
- R9: `rd_data` is updated only at a read edge and holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 1 | Address match for the status word |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe (no effect on contents) |
| dsr_n_pin | input | 1 | Asynchronous active-low data-set-ready line |
| ie_modem | input | 1 | Modem-status interrupt enable |
| rd_data | output | DATA_W | Registered status word from the last read |
| irq_modem | output | 1 | Registered modem-status interrupt request |

## Verification
Each pin toggle moves through two synchronizer flops and then the flag register. The flag therefore changes at the third rising edge after the toggle. A read strobe samples the pre-edge flag and level into `rd_data` at its own edge, and `irq_modem` follows the next flag state at that same edge. The bench drives every input on the falling edge and samples one falling edge later. It keeps a per-edge model built from these delays, so each comparison lands on the exact edge where a result becomes due. The directed parts place reads two, three and four edges after a toggle to hit the coincident-read case and the first edge at which the new level becomes visible.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int LVL_POS = 5;
  localparam int DLT_POS = 1;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) ff <= RST_VAL;
        else     ff <= d_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= {ff[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = ff[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_sync,
  input  logic clr_req,
  output logic chg,
  output logic flag,
  output logic flag_nxt
);
  logic lvl_prev;

  assign chg      = lvl_sync ^ lvl_prev;
  // a change outranks the clear so an edge during a read is kept
  assign flag_nxt = chg | (flag & ~clr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= IDLE_LVL;
      flag     <= 1'b0;
    end else begin
      lvl_prev <= lvl_sync;
      flag     <= flag_nxt;
    end
  end
endmodule

// File: rtl/mdm_status_unit.sv
module mdm_status_unit #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic              dsr_n_pin,
  input  logic              ie_modem,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_modem
);
  import mdm_pkg::*;

  logic lvl_sync;
  logic rd_hit;
  logic chg;
  logic dlt_flag;
  logic dlt_nxt;
  logic [DATA_W-1:0] status_w;

  // write wins over read: a combined access is a write and is ignored
  assign rd_hit = reg_sel & reg_rd & ~reg_wr;

  mdm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (dsr_n_pin),
    .q_sync  (lvl_sync)
  );

  mdm_delta #(.IDLE_LVL(1'b1)) u_delta (
    .clk      (clk),
    .rst      (rst),
    .lvl_sync (lvl_sync),
    .clr_req  (rd_hit),
    .chg      (chg),
    .flag     (dlt_flag),
    .flag_nxt (dlt_nxt)
  );

  always_comb begin
    status_w          = '0;
    status_w[LVL_POS] = ~lvl_sync;
    status_w[DLT_POS] = dlt_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      irq_modem <= 1'b0;
    end else begin
      if (rd_hit) rd_data <= status_w;
      irq_modem <= dlt_nxt & ie_modem;
    end
  end
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_hit,
  input logic              wr_hit,
  input logic              chg,
  input logic              flag,
  input logic              lvl,
  input logic              ie_modem,
  input logic              irq_modem,
  input logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] USED =
    (DATA_W'(1) << mdm_pkg::LVL_POS) | (DATA_W'(1) << mdm_pkg::DLT_POS);

  AST_RSV_ZERO:  assert property (@(posedge clk) disable iff (rst) (rd_data & ~USED) == '0); // R8
  AST_FLAG_SET:  assert property (@(posedge clk) disable iff (rst) chg |=> flag); // R3
  AST_FLAG_CLR:  assert property (@(posedge clk) disable iff (rst) (rd_hit && !chg) |=> !flag); // R4
  AST_RD_OLD:    assert property (@(posedge clk) disable iff (rst) rd_hit |=> rd_data[mdm_pkg::DLT_POS] == $past(flag)); // R5
  AST_RD_LVL:    assert property (@(posedge clk) disable iff (rst) rd_hit |=> rd_data[mdm_pkg::LVL_POS] == !$past(lvl)); // R2
  AST_WR_IGN:    assert property (@(posedge clk) disable iff (rst) (wr_hit && !chg) |=> ($stable(flag) && $stable(rd_data))); // R7
  AST_RD_HOLD:   assert property (@(posedge clk) disable iff (rst) !rd_hit |=> $stable(rd_data)); // R9
  AST_IRQ_TRACK: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> irq_modem == (flag && $past(ie_modem))); // R6
endmodule

bind mdm_status_unit mdm_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_hit    (rd_hit),
  .wr_hit    (reg_sel & reg_wr),
  .chg       (chg),
  .flag      (dlt_flag),
  .lvl       (lvl_sync),
  .ie_modem  (ie_modem),
  .irq_modem (irq_modem),
  .rd_data   (rd_data)
);

// File: tb/sim_mdm_status_unit.sv
module sim_mdm_status_unit;
  localparam int PERIOD = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_sel = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
  logic dsr_n_pin = 1'b1, ie_modem = 1'b0;
  logic [DW-1:0] rd_data;
  logic irq_modem;

  int checks = 0;
  int errors = 0;

  // bench model, advanced once per rising edge from the requirement timing
  logic m_s1 = 1'b1, m_s2 = 1'b1, m_prev = 1'b1, m_flag = 1'b0, m_irq = 1'b0;
  logic [DW-1:0] m_rd = '0;

  always #(PERIOD/2) clk = ~clk;

  mdm_status_unit #(.DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .dsr_n_pin(dsr_n_pin), .ie_modem(ie_modem), .rd_data(rd_data), .irq_modem(irq_modem)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, advance the model for the coming rising edge,
  // then compare one falling edge later
  task automatic cyc(input logic pin, input logic rd, input logic wr,
                     input logic sel, input logic ie);
    logic hit, c, nf;
    dsr_n_pin = pin; reg_rd = rd; reg_wr = wr; reg_sel = sel; ie_modem = ie;
    hit = rd & sel & ~wr;
    c   = m_s2 ^ m_prev;
    nf  = c | (m_flag & ~hit);
    if (hit) m_rd = (DW'(~m_s2) << 5) | (DW'(m_flag) << 1);
    m_irq = ie & nf; m_flag = nf; m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    @(posedge clk);
    @(negedge clk);
    chk("R2 level bit", DW'(rd_data[5]), DW'(m_rd[5]));
    chk("R3 or R4 flag bit", DW'(rd_data[1]), DW'(m_rd[1]));
    chk("R8 reserved bits", rd_data & ~DW'(32'h22), '0);
    chk("R6 irq", DW'(irq_modem), DW'(m_irq));
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 reset rd_data", rd_data, '0);
    chk("R1 reset irq", DW'(irq_modem), '0);
    cyc(1, 1, 0, 1, 0);
    chk("R1 first read", rd_data, '0);

    // falling transition, read at fourth edge
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    cyc(0, 1, 0, 1, 0);
    chk("R3 falling sets flag", rd_data, 32'h22);
    cyc(0, 1, 0, 1, 0);
    chk("R4 read cleared flag", rd_data, 32'h20);

    // rising transition with enable on
    cyc(0, 0, 0, 0, 1);
    chk("R6 no irq without flag", DW'(irq_modem), '0);
    cyc(1, 0, 0, 0, 1); cyc(1, 0, 0, 0, 1); cyc(1, 0, 0, 0, 1);
    chk("R6 irq on flag set", DW'(irq_modem), 1);
    cyc(1, 1, 0, 1, 1);
    chk("R3 rising sets flag", rd_data, 32'h02);
    chk("R6 irq drops after clear", DW'(irq_modem), '0);

    // R9 hold across toggles without reads
    cyc(0, 0, 0, 1, 0); cyc(0, 1, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    chk("R9 rd_data held", rd_data, 32'h02);
    // R7 write and read+write ignored
    cyc(0, 0, 1, 1, 0);
    chk("R7 write keeps rd_data", rd_data, 32'h02);
    cyc(0, 1, 1, 1, 0);
    chk("R7 read+write keeps rd_data", rd_data, 32'h02);
    cyc(0, 1, 0, 1, 0);
    chk("R7 flag survived writes", rd_data, 32'h22);
    cyc(0, 1, 0, 1, 0);
    chk("R4 flag cleared", rd_data, 32'h20);

    // R5 read coinciding with detection at third edge
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 1, 0);
    chk("R5 coincident read old value", rd_data, 32'h00);
    cyc(1, 1, 0, 1, 0);
    chk("R5 flag kept", rd_data, 32'h02);
    // R2 read at second edge still shows old level
    cyc(0, 0, 0, 0, 0);
    cyc(0, 1, 0, 1, 0);
    chk("R2 old level at second edge", rd_data, 32'h00);
    cyc(0, 1, 0, 1, 0);
    chk("R2 new level at third edge", rd_data, 32'h20);

    // sweep with pseudo-random stimulus
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc(lf[0] ^ lf[7], lf[1] & lf[3], lf[2] & lf[5] & lf[9], lf[4] | lf[6], lf[8]);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule